// File: doc/BRIEF.md
# Peripheral Clock Gate with Turn-Off Hysteresis

This block decides, cycle by cycle, whether one peripheral clock runs, and it produces that clock. The request to run comes from one of two owners. Under software ownership a software enable input sets the request. Under hardware ownership a hardware request input sets it. Either request is qualified by a policy-allow input from the power policy logic. A build-time option marks the gate as never-disable. Such a gate runs its clock permanently, whatever the inputs say.

Turning the clock on takes effect at the next clock edge. Turning it off can be held back by a hysteresis timer. The timer is switched by a hysteresis-enable input, and a length input picks a short or a long delay. A new request that arrives during the delay cancels it, so the clock never drops. The block drives a registered clock-enable output and a gated clock made with a latch, so the gated clock cannot glitch. It also drives a status output, which is the enable passed through a synchroniser and shows the real gate state a fixed number of edges later.

Top module: `periph_clk_gate`

## Requirements
- R1: While `rst_ni` is low, `clk_en_o`, `status_o` and `gclk_o` are 0.
- R2: With `own_sw_i`=1 (software owns the gate), the request equals `sw_en_i`, and `hw_req_i` has no effect on `clk_en_o`.
- R3: With `own_sw_i`=0 (hardware owns the gate), the request equals `hw_req_i`, and `sw_en_i` has no effect on `clk_en_o`.
- R4: With `policy_allow_i`=0, the request is 0 whatever the owner's input is (this does not apply to a never-disable gate).
- R5: Turn-on has no delay. If the request is 1 at a rising edge, `clk_en_o` is 1 after that edge.
- R6: With `hyst_en_i`=0, `clk_en_o` falls at the first rising edge that sees the request at 0.
- R7: With `hyst_en_i`=1 and `hyst_long_i`=0, `clk_en_o` stays 1 for LO_DLY (default 8) more edges after the first edge that sees the request at 0. It falls at the edge LO_DLY after that one.
- R8: With `hyst_en_i`=1 and `hyst_long_i`=1, the same rule applies with HI_DLY (default 64).
- R9: A request that returns during the delay keeps `clk_en_o` at 1. The next drop of the request restarts the full delay, and `clk_en_o` never falls while the request is 1.
- R10: With NEVER_OFF=1, `clk_en_o` and `status_o` are held at 1 from the edges that follow reset, regardless of every control input.
- R11: `status_o` equals `clk_en_o` delayed by SYNC_STAGES (default 2) rising edges.
- R12: `gclk_o` is high only in clock-high phases, and only when the enable was 1 during the low phase just before. A change of the enable made at a rising edge reaches `gclk_o` one full clock-high phase later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| own_sw_i | input | 1 | 1: software owns the gate, 0: hardware owns it |
| sw_en_i | input | 1 | Software run request |
| hw_req_i | input | 1 | Hardware run request |
| policy_allow_i | input | 1 | Power policy permits the clock |
| hyst_en_i | input | 1 | Enables the turn-off delay |
| hyst_long_i | input | 1 | 1: long delay (HI_DLY), 0: short delay (LO_DLY) |
| clk_en_o | output | 1 | Registered clock enable after hysteresis |
| gclk_o | output | 1 | Glitch-free gated clock |
| status_o | output | 1 | Synchronised gate state |

## Verification
The bench builds two instances with the default delays of 8 and 64 cycles and a two-flop status synchroniser. These delays are short enough that every edge of both countdowns can be sampled in turn, so an off-by-one at either end is exposed. One instance is an ordinary gate, on which ownership, policy, hysteresis, cancellation and gated-clock phase are exercised. The second shares the same inputs but is built with NEVER_OFF=1, which shows that the same stimulus cannot stop a never-disable clock.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;
  typedef enum logic {
    OWNER_HW = 1'b0,
    OWNER_SW = 1'b1
  } owner_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ckg_demand.sv
`timescale 1ns/1ps
module ckg_demand
  import ckg_pkg::*;
#(
  parameter bit NEVER_OFF = 1'b0
) (
  input  logic own_sw_i,
  input  logic sw_en_i,
  input  logic hw_req_i,
  input  logic allow_i,
  output logic want_o
);
  owner_e owner;
  logic   owner_req;

  assign owner = owner_e'(own_sw_i);

  always_comb begin
    unique case (owner)
      OWNER_SW: owner_req = sw_en_i;
      default:  owner_req = hw_req_i;
    endcase
  end

  generate
    if (NEVER_OFF) begin : g_keep
      assign want_o = 1'b1;
    end else begin : g_norm
      assign want_o = owner_req & allow_i;
    end
  endgenerate
endmodule

// File: rtl/ckg_hyst_timer.sv
`timescale 1ns/1ps
module ckg_hyst_timer
  import ckg_pkg::*;
#(
  parameter int unsigned LO_DLY = 8,
  parameter int unsigned HI_DLY = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic hyst_en_i,
  input  logic hyst_long_i,
  output logic en_o
);
  localparam int unsigned MAX_DLY = (HI_DLY > LO_DLY) ? HI_DLY : LO_DLY;
  localparam int unsigned CNT_W   = cnt_width(MAX_DLY);
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(LO_DLY);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HI_DLY);

  logic             en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;

  assign limit = hyst_long_i ? HI_LIM : LO_LIM;

  always_comb begin
    en_d  = en_q;
    cnt_d = cnt_q;
    if (want_i) begin
      en_d  = 1'b1;
      cnt_d = '0;
    end else if (en_q) begin
      if (!hyst_en_i || (cnt_q >= limit)) begin
        en_d  = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/ckg_sync.sv
`timescale 1ns/1ps
module ckg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = d_i;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ckg_glitchfree.sv
`timescale 1ns/1ps
module ckg_glitchfree (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  always_latch begin
    if (!rst_ni)     en_lat = 1'b0;
    else if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/periph_clk_gate.sv
`timescale 1ns/1ps
module periph_clk_gate #(
  parameter bit          NEVER_OFF   = 1'b0,
  parameter int unsigned LO_DLY      = 8,
  parameter int unsigned HI_DLY      = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_sw_i,
  input  logic sw_en_i,
  input  logic hw_req_i,
  input  logic policy_allow_i,
  input  logic hyst_en_i,
  input  logic hyst_long_i,
  output logic clk_en_o,
  output logic gclk_o,
  output logic status_o
);
  logic want;
  logic en;

  ckg_demand #(.NEVER_OFF(NEVER_OFF)) u_demand (
    .own_sw_i (own_sw_i),
    .sw_en_i  (sw_en_i),
    .hw_req_i (hw_req_i),
    .allow_i  (policy_allow_i),
    .want_o   (want)
  );

  ckg_hyst_timer #(.LO_DLY(LO_DLY), .HI_DLY(HI_DLY)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .want_i      (want),
    .hyst_en_i   (hyst_en_i),
    .hyst_long_i (hyst_long_i),
    .en_o        (en)
  );

  ckg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en),
    .q_o    (status_o)
  );

  ckg_glitchfree u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .gclk_o (gclk_o)
  );

  assign clk_en_o = en;
endmodule

// File: rtl/periph_clk_gate_chk.sv
`timescale 1ns/1ps
module periph_clk_gate_chk #(
  parameter bit          NEVER_OFF   = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic own_sw_i,
  input logic sw_en_i,
  input logic hw_req_i,
  input logic policy_allow_i,
  input logic hyst_en_i,
  input logic clk_en_o,
  input logic status_o
);
  logic req;
  assign req = NEVER_OFF ? 1'b1
             : (policy_allow_i && (own_sw_i ? sw_en_i : hw_req_i));

  // R5: a request is honoured at the very next edge
  p_turn_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> clk_en_o);

  // R6: without hysteresis the enable drops at the next edge
  p_no_hyst_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req && !hyst_en_i) |=> !clk_en_o);

  // R9: the enable only falls when the request was absent
  p_drop_unrequested_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> !$past(req));

  generate
    if (NEVER_OFF) begin : g_keep
      // R10: never-disable gate stays on
      p_keep_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> clk_en_o);
    end
    if (SYNC_STAGES == 2) begin : g_lag
      // R11: status trails the enable by two edges
      p_status_lag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o == $past(clk_en_o, 2));
    end
  endgenerate
endmodule

bind periph_clk_gate periph_clk_gate_chk #(
  .NEVER_OFF   (NEVER_OFF),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .own_sw_i       (own_sw_i),
  .sw_en_i        (sw_en_i),
  .hw_req_i       (hw_req_i),
  .policy_allow_i (policy_allow_i),
  .hyst_en_i      (hyst_en_i),
  .clk_en_o       (clk_en_o),
  .status_o       (status_o)
);

// File: tb/test_periph_clk_gate.sv
`timescale 1ns/1ps
module test_periph_clk_gate;
  logic clk, rst_n;
  logic own_sw, sw_en, hw_req, allow, hyst_en, hyst_long;
  logic en, gclk, st;
  logic en_k, gclk_k, st_k;
  int   checks, failures;
  bit   done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  periph_clk_gate #(.NEVER_OFF(1'b0)) i_periph_clk_gate (
    .clk_i(clk), .rst_ni(rst_n), .own_sw_i(own_sw), .sw_en_i(sw_en),
    .hw_req_i(hw_req), .policy_allow_i(allow), .hyst_en_i(hyst_en),
    .hyst_long_i(hyst_long), .clk_en_o(en), .gclk_o(gclk), .status_o(st));

  periph_clk_gate #(.NEVER_OFF(1'b1)) i_periph_clk_gate_keep (
    .clk_i(clk), .rst_ni(rst_n), .own_sw_i(own_sw), .sw_en_i(sw_en),
    .hw_req_i(hw_req), .policy_allow_i(allow), .hyst_en_i(hyst_en),
    .hyst_long_i(hyst_long), .clk_en_o(en_k), .gclk_o(gclk_k), .status_o(st_k));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 en", en, 1'b0);
    check("R1 status", st, 1'b0);
    @(posedge clk); #5;
    check("R1 gclk", gclk, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_software;
    own_sw = 1; allow = 1; hyst_en = 0; sw_en = 1;
    tick(1); check("R2/R5 on next edge", en, 1'b1);
    check("R11 status lag 1", st, 1'b0);
    tick(1); check("R11 status lag 2", st, 1'b0);
    tick(1); check("R11 status set", st, 1'b1);
    hw_req = 1; sw_en = 0;
    tick(1); check("R2/R6 hw ignored, off next edge", en, 1'b0);
    hw_req = 0;
    tick(3); check("R11 status clear", st, 1'b0);
  endtask

  task automatic t_hardware;
    own_sw = 0; sw_en = 1; hw_req = 0;
    tick(2); check("R3 sw ignored", en, 1'b0);
    hw_req = 1;
    tick(1); check("R3 hw on", en, 1'b1);
    hw_req = 0;
    tick(1); check("R3 hw off", en, 1'b0);
    sw_en = 0;
  endtask

  task automatic t_policy;
    own_sw = 0; hw_req = 1; allow = 0;
    tick(2); check("R4 blocked", en, 1'b0);
    allow = 1;
    tick(1); check("R4 allowed", en, 1'b1);
    allow = 0;
    tick(1); check("R4 withdrawn", en, 1'b0);
    hw_req = 0; allow = 1;
  endtask

  task automatic t_hyst(input logic long_sel, input int dly, input string req);
    own_sw = 1; hyst_en = 1; hyst_long = long_sel; sw_en = 1;
    tick(1); check(req, en, 1'b1);
    sw_en = 0;
    for (int i = 0; i < dly; i++) begin
      tick(1);
      if (i == 0 || i == dly - 1) check(req, en, 1'b1);
    end
    tick(1); check(req, en, 1'b0);
  endtask

  task automatic t_cancel;
    own_sw = 1; hyst_en = 1; hyst_long = 0; sw_en = 1;
    tick(1);
    sw_en = 0;
    tick(5); check("R9 mid delay", en, 1'b1);
    sw_en = 1;
    tick(1); check("R9 cancel", en, 1'b1);
    sw_en = 0;
    tick(8); check("R9 full restart", en, 1'b1);
    tick(1); check("R9 finally off", en, 1'b0);
    hyst_en = 0;
  endtask

  task automatic t_gclk;
    own_sw = 1; hyst_en = 0; sw_en = 1;
    @(posedge clk); #5; check("R12 held low in first high phase", gclk, 1'b0);
    @(posedge clk); #5; check("R12 runs next high phase", gclk, 1'b1);
    @(negedge clk); sw_en = 0;
    @(posedge clk); #5; check("R12 last pulse completes", gclk, 1'b1);
    @(posedge clk); #5; check("R12 stopped", gclk, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_keep;
    own_sw = 1; sw_en = 0; hw_req = 0; allow = 0; hyst_en = 0;
    tick(2);
    check("R10 keep en", en_k, 1'b1);
    check("R10 keep status", st_k, 1'b1);
    own_sw = 0;
    tick(2); check("R10 keep en hw", en_k, 1'b1);
    allow = 1;
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 0; own_sw = 0; sw_en = 0; hw_req = 0; allow = 0;
    hyst_en = 0; hyst_long = 0;
    tick(3);
    t_reset();
    rst_n = 1;
    tick(1);
    t_software();
    t_hardware();
    t_policy();
    t_hyst(1'b0, 8, "R7 short delay");
    t_hyst(1'b1, 64, "R8 long delay");
    t_cancel();
    t_gclk();
    t_keep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule